// File: doc/BRIEF.md
# Fractional-Baud UART with Receive and Transmit FIFOs

This block is an asynchronous serial port that sends and receives 8-bit characters with one start bit, one stop bit and no parity. Software reaches it over a byte-wide register bus. Writes to the data register queue characters in a 16-entry transmit FIFO. Received characters collect in a 16-entry receive FIFO and are popped by reads of the same offset.

Bit timing comes from a two-stage baud generator. The first stage is a 16-bit integer prescaler. The second stage adds a fractional stretch: a MUL/DIVADD ratio inserts an extra prescaler period after some ticks. Together they produce a tick at 16 times the bit rate. This allows common rates such as 115200 to be reached closely from almost any input clock.

The receiver samples each bit at the middle of its 16 ticks. An interrupt output stays high while the receive FIFO holds at least a programmable number of characters. Overrun and framing problems are reported in a line status register. Empty, full and overrun flags are also brought out as pins.

Top module: `uart_frac`

## Requirements
- R1: After reset, txd_o is high, irq_o is low, both FIFOs are empty, overrun_o is low, and line status (offset 5) reads 0x60.
- R2: Each transmitted character is framed on txd_o as a low start bit, then eight data bits least significant first, then a high stop bit. txd_o stays high while the transmitter is idle.
- R3: One bit lasts 16·D·(1 + A/M) clock cycles. Here D is the divisor: offset 0 holds the low byte and offset 1 the high byte, both reached while line control (offset 3) bit 7 is set. A is bits 3:0 and M is bits 7:4 of offset 7, with A < M. D = 0 behaves as 1. The stretch is applied by adding A to an accumulator on every tick and inserting one idle prescaler period each time the accumulator reaches M. Writing offsets 0/1 (divisor access set) or offset 7 restarts the prescaler and clears the accumulator.
- R4: The transmit FIFO holds 16 characters. tx_full_o is high when it holds 16, and a data write while it is full is discarded.
- R5: The receive FIFO holds 16 characters. A character that completes while the FIFO is full is dropped and sets overrun. Overrun appears on overrun_o and in line status bit 1, and clears when line status is read.
- R6: Reading offset 0 with divisor access clear returns the oldest received character and removes it. Characters leave in arrival order.
- R7: irq_o is high exactly while the receive FIFO count is at or above the trigger level. The level is set by bits 7:6 of offset 2: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R8: After a falling edge on rxd_i, the line is checked again after 8 ticks. If it is high by then, the start is dropped and nothing is stored.
- R9: A stop bit sampled low sets line status bit 3, and the character is still stored. Bit 3 clears when line status is read.
- R10: Writing offset 2 with bit 1 set empties the receive FIFO. Writing it with bit 2 set empties the transmit FIFO. A character already in the shifter is not affected.
- R11: The divisor bytes (offsets 0/1 with line control bit 7 set), the fraction register (offset 7) and line control bit 7 read back as written. Line control reads bits 1:0 as 11. Offset 1 reads 0 while divisor access is clear.
- R12: Line status bit 5 is high while the transmit FIFO is empty. Bit 6 is high only when, in addition, the shifter is idle. Bit 0 is high while received data is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops data or clears status) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Receive trigger-level interrupt |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |
| overrun_o | output | 1 | Sticky receive overrun flag |

## Verification
A wrong fractional accumulator or prescaler count shows up on the very next transmitted bit. The low start bit or the following high bit has a width that differs from the arithmetic value, so bit widths are measured over a sweep of divisors and fractions. A wrong FIFO pointer or count shows up as soon as the interrupt is compared against each trigger level at every fill count, or on the first pop, which returns a character out of order. Overrun and framing state errors appear in the first line status read after the provoking character. Receiver phase errors surface as a corrupted or spurious character one frame later.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;
  localparam int FRAC_W = 4;
  localparam int OSR    = 16;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_DLM  = 3'd1;
  localparam logic [2:0] ADDR_FCR  = 3'd2;
  localparam logic [2:0] ADDR_LCR  = 3'd3;
  localparam logic [2:0] ADDR_LSR  = 3'd5;
  localparam logic [2:0] ADDR_FRAC = 3'd7;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic [$clog2(DEPTH):0]       count_o,
  output logic                         empty_o,
  output logic                         full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rp];
  assign count_o = cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_baud.sv
module uart_baud
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [DIV_W-1:0]  dl_i,
  input  logic [FRAC_W-1:0] mul_i,
  input  logic [FRAC_W-1:0] add_i,
  output logic              tick_o
);
  localparam int AW = FRAC_W + 1;

  logic [DIV_W-1:0] cnt, dl_eff;
  logic [AW-1:0]    acc, sum, mul_eff;
  logic             stall, period_end;

  assign dl_eff     = (dl_i == '0) ? DIV_W'(1) : dl_i;
  assign mul_eff    = (mul_i == '0) ? AW'(1) : AW'(mul_i);
  assign period_end = (cnt >= dl_eff - DIV_W'(1));
  assign sum        = acc + AW'(add_i);
  assign tick_o     = period_end && !stall && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      acc   <= '0;
      stall <= 1'b0;
    end else if (restart_i) begin
      cnt   <= '0;
      acc   <= '0;
      stall <= 1'b0;
    end else if (period_end) begin
      cnt <= '0;
      if (stall) begin
        stall <= 1'b0;
      end else if (add_i != '0 && sum >= mul_eff) begin
        // accumulator wrapped: hold the next tick back by one period
        acc   <= sum - mul_eff;
        stall <= 1'b1;
      end else begin
        acc <= sum;
      end
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int SW = DATA_W + 2;
  localparam int BW = $clog2(SW);
  localparam int TW = $clog2(OSR);

  logic [SW-1:0] shreg;
  logic [BW-1:0] bcnt;
  logic [TW-1:0] tcnt;

  assign pop_o = tick_i && !busy_o && !empty_i;
  assign txd_o = shreg[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg  <= '1;
      bcnt   <= '0;
      tcnt   <= '0;
      busy_o <= 1'b0;
    end else if (pop_o) begin
      shreg  <= {1'b1, data_i, 1'b0};
      bcnt   <= '0;
      tcnt   <= '0;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      tcnt <= tcnt + TW'(1);
      if (tcnt == TW'(OSR - 1)) begin
        shreg <= {1'b1, shreg[SW-1:1]};
        bcnt  <= bcnt + BW'(1);
        if (bcnt == BW'(SW - 1)) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic              ferr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W);

  rx_state_e     state;
  logic [1:0]    sync;
  logic          rxs;
  logic [TW-1:0] cnt;
  logic [BW-1:0] bitn;

  assign rxs = sync[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync   <= 2'b11;
      state  <= RX_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      data_o <= '0;
      done_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      sync   <= {sync[0], rxd_i};
      done_o <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rxs) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: if (tick_i) begin
          if (cnt == TW'(OSR / 2 - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            state <= rxs ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        RX_DATA: if (tick_i) begin
          cnt <= cnt + TW'(1);
          if (cnt == TW'(OSR - 1)) begin
            data_o <= {rxs, data_o[DATA_W-1:1]};
            bitn   <= bitn + BW'(1);
            if (bitn == BW'(DATA_W - 1)) state <= RX_STOP;
          end
        end
        RX_STOP: if (tick_i) begin
          cnt <= cnt + TW'(1);
          if (cnt == TW'(OSR - 1)) begin
            done_o <= 1'b1;
            ferr_o <= !rxs;
            state  <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frac.sv
module uart_frac
  import uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       irq_o,
  output logic       tx_empty_o,
  output logic       tx_full_o,
  output logic       rx_empty_o,
  output logic       rx_full_o,
  output logic       overrun_o
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic [DIV_W-1:0]  dl;
  logic [FRAC_W-1:0] frac_mul, frac_add;
  logic              dlab, ferr, ovr;
  logic [1:0]        trig_sel;

  logic              tick, tx_busy, tx_pop, tx_push, rx_pop, rx_push;
  logic              lsr_rd, fcr_wr, baud_restart;
  logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
  logic              rx_done, rx_ferr;
  logic [CW-1:0]     tx_count, rx_count;
  logic [7:0]        lsr;

  assign tx_push      = wr_i && addr_i == ADDR_DATA && !dlab;
  assign rx_pop       = rd_i && addr_i == ADDR_DATA && !dlab;
  assign lsr_rd       = rd_i && addr_i == ADDR_LSR;
  assign fcr_wr       = wr_i && addr_i == ADDR_FCR;
  assign baud_restart = wr_i && ((dlab && (addr_i == ADDR_DATA || addr_i == ADDR_DLM))
                                 || addr_i == ADDR_FRAC);
  assign rx_push      = rx_done && !rx_full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl       <= DIV_W'(1);
      frac_mul <= FRAC_W'(1);
      frac_add <= '0;
      dlab     <= 1'b0;
      trig_sel <= 2'd0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_DATA: if (dlab) dl[7:0] <= wdata_i;
        ADDR_DLM:  if (dlab) dl[15:8] <= wdata_i;
        ADDR_FCR:  trig_sel <= wdata_i[7:6];
        ADDR_LCR:  dlab <= wdata_i[7];
        ADDR_FRAC: {frac_mul, frac_add} <= wdata_i;
        default: ;
      endcase
    end
  end

  // set wins over the clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr  <= 1'b0;
      ferr <= 1'b0;
    end else begin
      if (rx_done && rx_full_o) ovr <= 1'b1;
      else if (lsr_rd)          ovr <= 1'b0;
      if (rx_done && rx_ferr)   ferr <= 1'b1;
      else if (lsr_rd)          ferr <= 1'b0;
    end
  end

  uart_baud u_baud (
    .clk_i, .rst_ni,
    .restart_i (baud_restart),
    .dl_i      (dl),
    .mul_i     (frac_mul),
    .add_i     (frac_add),
    .tick_o    (tick)
  );

  uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (fcr_wr && wdata_i[2]),
    .push_i  (tx_push),
    .din_i   (wdata_i),
    .pop_i   (tx_pop),
    .dout_o  (tx_head),
    .count_o (tx_count),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o)
  );

  uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (fcr_wr && wdata_i[1]),
    .push_i  (rx_push),
    .din_i   (rx_byte),
    .pop_i   (rx_pop),
    .dout_o  (rx_head),
    .count_o (rx_count),
    .empty_o (rx_empty_o),
    .full_o  (rx_full_o)
  );

  uart_tx u_tx (
    .clk_i, .rst_ni,
    .tick_i  (tick),
    .empty_i (tx_empty_o),
    .data_i  (tx_head),
    .pop_o   (tx_pop),
    .busy_o  (tx_busy),
    .txd_o
  );

  uart_rx u_rx (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .rxd_i,
    .done_o (rx_done),
    .ferr_o (rx_ferr),
    .data_o (rx_byte)
  );

  assign irq_o     = rx_count >= CW'(trig_level(trig_sel));
  assign overrun_o = ovr;
  assign lsr       = {1'b0, tx_empty_o && !tx_busy, tx_empty_o, 1'b0,
                      ferr, 1'b0, ovr, !rx_empty_o};

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      ADDR_DATA: rdata_o = dlab ? dl[7:0] : rx_head;
      ADDR_DLM:  rdata_o = dlab ? dl[15:8] : 8'h00;
      ADDR_LCR:  rdata_o = {dlab, 7'b0000011};
      ADDR_LSR:  rdata_o = lsr;
      ADDR_FRAC: rdata_o = {frac_mul, frac_add};
      default:   rdata_o = 8'h00;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^tx_count;
endmodule

// File: rtl/uart_frac_chk.sv
module uart_frac_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic txd_o,
  input logic irq_o,
  input logic tx_empty_o,
  input logic tx_full_o,
  input logic rx_empty_o,
  input logic rx_full_o,
  input logic overrun_o,
  input logic tx_busy
);
  // R7
  irq_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !rx_empty_o);

  // R5
  rx_flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full_o && rx_empty_o));

  // R4
  tx_flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o));

  // R5
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_full_o));

  // R4
  tx_full_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_full_o) |-> $past(wr_i));

  // R2
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);
endmodule

bind uart_frac uart_frac_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .txd_o      (txd_o),
  .irq_o      (irq_o),
  .tx_empty_o (tx_empty_o),
  .tx_full_o  (tx_full_o),
  .rx_empty_o (rx_empty_o),
  .rx_full_o  (rx_full_o),
  .overrun_o  (overrun_o),
  .tx_busy    (tx_busy)
);

// File: tb/tb_uart_frac.sv
module tb_uart_frac;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr;
  logic       wr, rd;
  logic [7:0] wdata, rdata;
  logic       txd, irq, tx_empty, tx_full, rx_empty, rx_full, ovr;
  logic       loop_en, rx_drv, rxd;
  int         checks = 0;
  int         fails = 0;

  always #(CLK_P / 2) clk = ~clk;
  assign rxd = loop_en ? txd : rx_drv;

  uart_frac dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_i (wr), .rd_i (rd),
    .wdata_i (wdata), .rdata_o (rdata), .rxd_i (rxd), .txd_o (txd),
    .irq_o (irq), .tx_empty_o (tx_empty), .tx_full_o (tx_full),
    .rx_empty_o (rx_empty), .rx_full_o (rx_full), .overrun_o (ovr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_baud(input int dl, input int m, input int a);
    wr_reg(3'd3, 8'h80);
    wr_reg(3'd0, 8'(dl));
    wr_reg(3'd1, 8'(dl >> 8));
    wr_reg(3'd7, {4'(m), 4'(a)});
    wr_reg(3'd3, 8'h03);
  endtask

  task automatic wait_sig(input string req, ref logic s, input int lim);
    int n = 0;
    while (s !== 1'b1 && n < lim) begin @(negedge clk); n++; end
    check(req, int'(s), 1);
  endtask

  task automatic meas(output int lo, output int hi);
    int n = 0;
    lo = 0; hi = 0;
    while (txd !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
    while (txd === 1'b0 && lo < 5000) begin @(negedge clk); lo++; end
    while (txd === 1'b1 && hi < 5000) begin @(negedge clk); hi++; end
  endtask

  task automatic frame_chk(input logic [7:0] b, input int bw);
    int n = 0;
    while (txd !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
    repeat (bw / 2) @(negedge clk);
    check("R2 start", int'(txd), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bw) @(negedge clk);
      check("R2 data", int'(txd), int'(b[i]));
    end
    repeat (bw) @(negedge clk);
    check("R2 stop", int'(txd), 1);
  endtask

  task automatic drive_rx(input logic [7:0] b, input logic stop_v);
    @(negedge clk); rx_drv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = b[i];
      repeat (16) @(negedge clk);
    end
    rx_drv = stop_v;
    repeat (stop_v ? 16 : 10) @(negedge clk);
    rx_drv = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lo, hi, bw;
    int mv[5] = '{1, 2, 4, 4, 8};
    int av[5] = '{0, 1, 1, 3, 5};
    int lv[4] = '{1, 4, 8, 14};
    addr = '0; wr = 0; rd = 0; wdata = '0; loop_en = 0; rx_drv = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 txd", int'(txd), 1);
    check("R1 irq", int'(irq), 0);
    check("R1 tx_empty", int'(tx_empty), 1);
    check("R1 rx_empty", int'(rx_empty), 1);
    check("R1 overrun", int'(ovr), 0);
    rd_reg(3'd5, d); check("R1 lsr", int'(d), 8'h60);

    // R11 register readback
    wr_reg(3'd3, 8'h80); wr_reg(3'd0, 8'h34); wr_reg(3'd1, 8'h12);
    rd_reg(3'd0, d); check("R11 dll", int'(d), 8'h34);
    rd_reg(3'd1, d); check("R11 dlm", int'(d), 8'h12);
    rd_reg(3'd3, d); check("R11 lcr", int'(d), 8'h83);
    wr_reg(3'd7, 8'h53);
    rd_reg(3'd7, d); check("R11 frac", int'(d), 8'h53);
    set_baud(1, 1, 0);
    rd_reg(3'd3, d); check("R11 lcr off", int'(d), 8'h03);
    rd_reg(3'd1, d); check("R11 off1", int'(d), 0);

    // R3 bit width sweep over divisor and fraction
    for (int dl = 0; dl < 4; dl++) begin
      for (int k = 0; k < 5; k++) begin
        bw = (dl == 0 ? 1 : dl) * (16 + 16 * av[k] / mv[k]);
        set_baud(dl, mv[k], av[k]);
        wr_reg(3'd0, 8'h55);
        meas(lo, hi);
        check("R3 start width", lo, bw);
        check("R3 bit0 width", hi, bw);
        repeat (12 * bw) @(negedge clk);
      end
    end

    // R2 frame layout
    set_baud(2, 4, 1);
    wr_reg(3'd0, 8'hA7); frame_chk(8'hA7, 40); repeat (80) @(negedge clk);
    wr_reg(3'd0, 8'h3C); frame_chk(8'h3C, 40); repeat (80) @(negedge clk);

    // R12 status bits with loopback
    set_baud(1, 1, 0);
    wr_reg(3'd2, 8'h06);
    loop_en = 1'b1;
    wr_reg(3'd0, 8'h11);
    repeat (20) @(negedge clk);
    rd_reg(3'd5, d); check("R12 shifting", int'(d & 8'h60), 8'h20);
    repeat (200) @(negedge clk);
    rd_reg(3'd5, d); check("R12 idle", int'(d & 8'h61), 8'h61);
    rd_reg(3'd0, d); check("R6 loop byte", int'(d), 8'h11);
    check("R6 empty after pop", int'(rx_empty), 1);

    // R4 transmit FIFO depth, 17th write dropped
    set_baud(64, 1, 0);
    for (int i = 0; i < 17; i++) wr_reg(3'd0, 8'(i));
    check("R4 tx_full", int'(tx_full), 1);
    set_baud(1, 1, 0);
    wait_sig("R4 rx fills", rx_full, 6000);
    repeat (400) @(negedge clk);
    check("R4 no 17th overrun", int'(ovr), 0);

    // R7 trigger sweep at every fill count, R6 order
    for (int c = 16; c >= 1; c--) begin
      for (int s = 0; s < 4; s++) begin
        wr_reg(3'd2, {2'(s), 6'b0});
        check("R7 irq level", int'(irq), (c >= lv[s]) ? 1 : 0);
      end
      rd_reg(3'd0, d); check("R6 order", int'(d), 16 - c);
    end
    check("R4 17th dropped", int'(rx_empty), 1);
    for (int s = 0; s < 4; s++) begin
      wr_reg(3'd2, {2'(s), 6'b0});
      check("R7 irq empty", int'(irq), 0);
    end

    // R5 overrun
    for (int i = 0; i < 16; i++) wr_reg(3'd0, 8'(8'h40 + i));
    wait_sig("R5 rx fills", rx_full, 6000);
    wr_reg(3'd0, 8'h99);
    repeat (300) @(negedge clk);
    check("R5 overrun pin", int'(ovr), 1);
    rd_reg(3'd5, d); check("R5 lsr ovr", int'(d[1]), 1);
    check("R5 overrun cleared", int'(ovr), 0);
    rd_reg(3'd5, d); check("R5 lsr ovr clear", int'(d[1]), 0);
    for (int i = 0; i < 16; i++) begin
      rd_reg(3'd0, d); check("R5 kept data", int'(d), 8'h40 + i);
    end
    check("R5 drained", int'(rx_empty), 1);

    // R10 FIFO clears
    loop_en = 1'b0;
    set_baud(64, 1, 0);
    wr_reg(3'd0, 8'h01); wr_reg(3'd0, 8'h02); wr_reg(3'd0, 8'h03);
    check("R10 tx loaded", int'(tx_empty), 0);
    wr_reg(3'd2, 8'h04);
    check("R10 tx cleared", int'(tx_empty), 1);
    set_baud(1, 1, 0);
    repeat (100) @(negedge clk);
    check("R10 line idle", int'(txd), 1);
    drive_rx(8'h5A, 1'b1);
    check("R10 rx loaded", int'(rx_empty), 0);
    wr_reg(3'd2, 8'h02);
    check("R10 rx cleared", int'(rx_empty), 1);

    // R8 short start pulse rejected
    @(negedge clk); rx_drv = 1'b0;
    repeat (4) @(negedge clk); rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    check("R8 glitch dropped", int'(rx_empty), 1);
    drive_rx(8'h9A, 1'b1);
    rd_reg(3'd0, d); check("R8 good byte", int'(d), 8'h9A);
    rd_reg(3'd5, d); check("R8 lsr clean", int'(d & 8'h0B), 0);

    // R9 framing error
    drive_rx(8'h3C, 1'b0);
    rd_reg(3'd5, d);
    check("R9 ferr set", int'(d[3]), 1);
    check("R9 data ready", int'(d[0]), 1);
    rd_reg(3'd0, d); check("R9 byte kept", int'(d), 8'h3C);
    rd_reg(3'd5, d); check("R9 ferr cleared", int'(d[3]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule